// File: doc/BRIEF.md
# Rotated Immediate Constant Encoder

This block takes a 32-bit constant and finds out whether an instruction can carry it in a short immediate field. That field holds an 8-bit value and a 4-bit rotation code. The value the field stands for is the 8-bit value rotated right by twice the rotation code, so only even rotation amounts from 0 to 30 can be expressed. If the constant does not fit that form, the block tries again on the bitwise complement of the constant. A hit there means a move-complement instruction can produce the constant. If both attempts fail, the block raises a flag telling the code generator to load the constant from a literal pool or to build it over several instructions.

A constant enters through a valid/ready handshake. Each accepted constant produces exactly one registered result, which appears on the clock edge after acceptance. The result fields keep their value until the next constant is accepted, so a consumer can read them whenever it likes. There is no backpressure on the result side. After reset is released, the input side becomes ready and stays ready on every cycle.

Top module: `rot_imm_enc`

## Requirements
- R1: For a constant that fits directly, the result has `res_inv`=0 and `res_pool`=0. Rotating `res_imm` (zero-extended to 32 bits) right by 2×`res_rot` gives back the constant. Examples: 0x000000FF gives imm 0xFF, rot 0. 0xF000000F gives imm 0xFF, rot 2. 0x80000001 gives imm 0x06, rot 1.
- R2: A pattern that needs an odd rotation is not encoded directly. 0xE000001F, whose complement does not fit either, is reported with `res_pool`=1.
- R3: When several rotation codes encode the same word, the smallest one is reported. 0x00000300 gives imm 0x03, rot 12. 0x00000000 gives imm 0x00, rot 0.
- R4: When the constant does not fit but its complement does, the result has `res_inv`=1 and `res_pool`=0. Rotating `res_imm` right by 2×`res_rot` gives the complement of the constant. Examples: 0x0FFFFFF0 gives imm 0xFF, rot 2. 0xFFFFFFFF gives imm 0x00, rot 0.
- R5: When neither the constant nor its complement fits, the result has `res_pool`=1, `res_inv`=0, `res_imm`=0 and `res_rot`=0.
- R6: `res_valid` is high for exactly one cycle, on the cycle after each accepted input (`in_valid` and `in_ready` both high at a rising edge). It is low on every other cycle.
- R7: While `rst_n` is low, `in_ready` and `res_valid` are low. After `rst_n` is released, `in_ready` rises after the second rising clock edge. An input offered before then is ignored and produces no result.
- R8: `res_inv`, `res_pool`, `res_imm` and `res_rot` keep their values on every cycle in which no input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It takes effect asynchronously and is released in step with the clock. |
| in_valid | input | 1 | A constant is offered |
| in_ready | output | 1 | The block can accept a constant |
| in_const | input | 32 | Constant to encode |
| res_valid | output | 1 | One-cycle pulse: a new result is available |
| res_inv | output | 1 | The result encodes the complement of the constant (move-complement form) |
| res_pool | output | 1 | The constant cannot be encoded in either form |
| res_imm | output | 8 | 8-bit immediate value |
| res_rot | output | 4 | Rotation code; the right rotation is twice this value |

## Verification
A wrong choice inside the block shows up on the very result that follows the faulty input, one cycle after acceptance. Examples are a rotation window taken at the wrong offset, a priority that prefers a larger rotation code, or the complement path taking precedence. In each case, re-expanding `res_imm` by `res_rot` no longer gives back the constant, or a smaller code than the one reported could have been used. A result register that captures its value without an accept changes fields that should have held steady. A handshake that is wrong emits a pulse nobody expects, or drops a result. The scoreboard notices either one on the next sampled cycle, or when the queue is drained at the end.

// File: rtl/rie_pkg.sv
package rie_pkg;

  // Outcome of an encoding attempt
  typedef enum logic [1:0] {
    FORM_DIRECT = 2'd0,
    FORM_INVERT = 2'd1,
    FORM_POOL   = 2'd2
  } form_e;

  // Default geometry of the immediate form
  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_IMM_W  = 8;

endpackage

// File: rtl/rie_rot_scan.sv
// Looks at every even rotation of one word and reports the smallest rotation
// code whose rotated window holds the word in the low IMM_W bits.
module rie_rot_scan #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned ROT_W  = $clog2(WORD_W / 2)
) (
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output logic [IMM_W-1:0]  imm,
  output logic [ROT_W-1:0]  rot
);

  localparam int unsigned NROT = WORD_W / 2;

  logic [2*WORD_W-1:0] dbl;
  logic [NROT-1:0]     fit;
  logic [IMM_W-1:0]    cand [NROT];

  assign dbl = {word, word};

  // Code r means value = imm ror 2r, so imm = word rol 2r
  for (genvar r = 0; r < NROT; r++) begin : g_rot
    localparam int unsigned SH = 2 * r;
    logic [WORD_W-1:0] rolled;
    assign rolled  = dbl[WORD_W-SH +: WORD_W];
    assign fit[r]  = ~|rolled[WORD_W-1:IMM_W];
    assign cand[r] = rolled[IMM_W-1:0];
  end

  // The lowest code wins: the scan runs downward, so the last hit assigned is the smallest
  always_comb begin
    hit = |fit;
    imm = '0;
    rot = '0;
    for (int r = NROT - 1; r >= 0; r--) begin
      if (fit[r]) begin
        imm = cand[r];
        rot = ROT_W'(r);
      end
    end
  end

endmodule

// File: rtl/rie_pick.sv
// Merges the direct and complemented scans; the direct form has priority.
module rie_pick
  import rie_pkg::*;
#(
  parameter int unsigned IMM_W = 8,
  parameter int unsigned ROT_W = 4
) (
  input  logic             dir_hit,
  input  logic [IMM_W-1:0] dir_imm,
  input  logic [ROT_W-1:0] dir_rot,
  input  logic             inv_hit,
  input  logic [IMM_W-1:0] inv_imm,
  input  logic [ROT_W-1:0] inv_rot,
  output form_e            form,
  output logic [IMM_W-1:0] imm,
  output logic [ROT_W-1:0] rot
);

  always_comb begin
    if (dir_hit) begin
      form = FORM_DIRECT;
      imm  = dir_imm;
      rot  = dir_rot;
    end else if (inv_hit) begin
      form = FORM_INVERT;
      imm  = inv_imm;
      rot  = inv_rot;
    end else begin
      form = FORM_POOL;
      imm  = '0;
      rot  = '0;
    end
  end

endmodule

// File: rtl/rot_imm_enc.sv
module rot_imm_enc
  import rie_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned IMM_W  = DEF_IMM_W,
  localparam int unsigned ROT_W = $clog2(WORD_W / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_const,
  output logic              res_valid,
  output logic              res_inv,
  output logic              res_pool,
  output logic [IMM_W-1:0]  res_imm,
  output logic [ROT_W-1:0]  res_rot
);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];
  assign in_ready  = rst_int_n;

  logic accept;
  assign accept = in_valid & in_ready;

  // Scans of the constant and of its complement
  logic             d_hit, i_hit;
  logic [IMM_W-1:0] d_imm, i_imm;
  logic [ROT_W-1:0] d_rot, i_rot;

  rie_rot_scan #(.WORD_W(WORD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_scan_dir (
    .word (in_const),
    .hit  (d_hit),
    .imm  (d_imm),
    .rot  (d_rot)
  );

  rie_rot_scan #(.WORD_W(WORD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_scan_inv (
    .word (~in_const),
    .hit  (i_hit),
    .imm  (i_imm),
    .rot  (i_rot)
  );

  form_e            sel_form;
  logic [IMM_W-1:0] sel_imm;
  logic [ROT_W-1:0] sel_rot;

  rie_pick #(.IMM_W(IMM_W), .ROT_W(ROT_W)) u_pick (
    .dir_hit (d_hit),
    .dir_imm (d_imm),
    .dir_rot (d_rot),
    .inv_hit (i_hit),
    .inv_imm (i_imm),
    .inv_rot (i_rot),
    .form    (sel_form),
    .imm     (sel_imm),
    .rot     (sel_rot)
  );

  // Next state
  logic             vld_d, inv_d, pool_d;
  logic [IMM_W-1:0] imm_d;
  logic [ROT_W-1:0] rot_d;
  logic             vld_q, inv_q, pool_q;
  logic [IMM_W-1:0] imm_q;
  logic [ROT_W-1:0] rot_q;

  always_comb begin
    vld_d  = accept;
    inv_d  = inv_q;
    pool_d = pool_q;
    imm_d  = imm_q;
    rot_d  = rot_q;
    if (accept) begin
      inv_d  = (sel_form == FORM_INVERT);
      pool_d = (sel_form == FORM_POOL);
      imm_d  = sel_imm;
      rot_d  = sel_rot;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= 1'b0;
      inv_q  <= 1'b0;
      pool_q <= 1'b0;
      imm_q  <= '0;
      rot_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      inv_q  <= inv_d;
      pool_q <= pool_d;
      imm_q  <= imm_d;
      rot_q  <= rot_d;
    end
  end

  assign res_valid = vld_q;
  assign res_inv   = inv_q;
  assign res_pool  = pool_q;
  assign res_imm   = imm_q;
  assign res_rot   = rot_q;

endmodule

// File: rtl/rot_imm_enc_chk.sv
module rot_imm_enc_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned ROT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_const,
  input logic              res_valid,
  input logic              res_inv,
  input logic              res_pool,
  input logic [IMM_W-1:0]  res_imm,
  input logic [ROT_W-1:0]  res_rot
);

  function automatic logic [WORD_W-1:0] expand(logic [IMM_W-1:0] imm, logic [ROT_W-1:0] rot);
    logic [WORD_W-1:0]   z;
    logic [2*WORD_W-1:0] d;
    z = WORD_W'(imm);
    d = {z, z} >> (2 * int'(rot));
    return d[WORD_W-1:0];
  endfunction

  // True when no code below rot can hold the value
  function automatic logic no_smaller(logic [WORD_W-1:0] v, logic [ROT_W-1:0] rot);
    logic [2*WORD_W-1:0] d;
    logic ok;
    ok = 1'b1;
    for (int r = 0; r < (1 << ROT_W); r++) begin
      if (r < int'(rot)) begin
        d = {v, v} << (2 * r);
        if (~|d[2*WORD_W-1 -: WORD_W-IMM_W]) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  logic accept;
  assign accept = in_valid && in_ready;

  // R1, R4: the reported fields re-expand to the accepted constant
  a_r1_reexpand: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_pool) |->
      ((expand(res_imm, res_rot) ^ {WORD_W{res_inv}}) == $past(in_const)));

  // R3: smallest rotation code
  a_r3_min_rot: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_pool) |->
      no_smaller($past(in_const) ^ {WORD_W{res_inv}}, res_rot));

  // R4: complement form never coexists with the pool flag
  a_r4_inv_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_inv) |-> !res_pool);

  // R5: pool result carries zeroed fields
  a_r5_pool_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pool) |-> (!res_inv && res_imm == '0 && res_rot == '0));

  // R6: one pulse per accept, none otherwise
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !res_valid);

  // R7: nothing ready or valid while reset is held
  a_r7_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!in_ready && !res_valid));

  // R8: fields hold without an accept
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(res_imm) && $stable(res_rot) && $stable(res_inv) && $stable(res_pool)));

endmodule

bind rot_imm_enc rot_imm_enc_chk #(.WORD_W(WORD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_const  (in_const),
  .res_valid (res_valid),
  .res_inv   (res_inv),
  .res_pool  (res_pool),
  .res_imm   (res_imm),
  .res_rot   (res_rot)
);

// File: tb/rot_imm_enc_tb.sv
module rot_imm_enc_tb;

  localparam int W  = 32;
  localparam int IW = 8;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [W-1:0]  in_const;
  logic          res_valid, res_inv, res_pool;
  logic [IW-1:0] res_imm;
  logic [RW-1:0] res_rot;

  rot_imm_enc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_const(in_const), .res_valid(res_valid), .res_inv(res_inv),
    .res_pool(res_pool), .res_imm(res_imm), .res_rot(res_rot)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [W-1:0]  c;
    logic          inv;
    logic          pool;
    logic [IW-1:0] imm;
    logic [RW-1:0] rot;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    errors = 0;
  int    checks = 0;
  bit    finished = 1'b0;
  logic [IW+RW+1:0] last_fields;

  function automatic logic [W-1:0] ror_w(logic [IW-1:0] imm, int amt);
    logic [W-1:0] z;
    z = W'(imm);
    return (amt == 0) ? z : ((z >> amt) | (z << (W - amt)));
  endfunction

  // Brute force over every (rotation, value) pair, smallest rotation first
  function automatic exp_t ref_model(logic [W-1:0] c);
    exp_t e;
    e = '0;
    e.c = c;
    e.pool = 1'b1;
    for (int pass = 0; pass < 2; pass++) begin
      for (int r = 0; r < 16; r++) begin
        for (int v = 0; v < 256; v++) begin
          if (e.pool && ror_w(IW'(v), 2 * r) == (pass == 0 ? c : ~c)) begin
            e.pool = 1'b0;
            e.inv  = (pass == 1);
            e.imm  = IW'(v);
            e.rot  = RW'(r);
          end
        end
      end
    end
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] c, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_const = c;
    exp_q.push_back(ref_model(c));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (res_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "result without accepted input", W'(res_valid), '0);
      end else begin
        exp_t  e;
        string t;
        logic [IW+RW+1:0] act, ex;
        e   = exp_q.pop_front();
        t   = tag_q.pop_front();
        act = {res_inv, res_pool, res_imm, res_rot};
        ex  = {e.inv, e.pool, e.imm, e.rot};
        check(act == ex, t, $sformatf("fields {inv,pool,imm,rot} for %h", e.c), W'(act), W'(ex));
        if (!res_pool) begin
          logic [W-1:0] back;
          back = ror_w(res_imm, 2 * int'(res_rot)) ^ {W{res_inv}};
          check(back == e.c, res_inv ? "R4" : "R1", "re-expanded value", back, e.c);
        end
        last_fields = act;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_const = '0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R7", "in_ready during reset", W'(in_ready), '0);
    check(res_valid == 1'b0, "R7", "res_valid during reset", W'(res_valid), '0);
    check({res_inv, res_pool, res_imm, res_rot} == '0, "R7", "result fields in reset",
          W'({res_inv, res_pool, res_imm, res_rot}), '0);

    // Release and offer an input before ready: must be ignored (R7)
    @(negedge clk);
    rst_n    = 1'b1;
    in_valid = 1'b1;
    in_const = 32'h0000_0042;
    @(negedge clk);
    check(in_ready == 1'b0, "R7", "in_ready one edge after release", W'(in_ready), '0);
    in_valid = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R7", "in_ready two edges after release", W'(in_ready), 1);
    check(res_valid == 1'b0, "R7", "no result for early input", W'(res_valid), '0);

    // Directed corners
    drive(32'h0000_00FF, "R1");
    drive(32'hF000_000F, "R1");
    drive(32'h8000_0001, "R1");
    drive(32'hE000_001F, "R2");
    drive(32'h0000_0300, "R3");
    drive(32'h0000_0000, "R3");
    drive(32'h0000_03FC, "R3");
    drive(32'h0FFF_FFF0, "R4");
    drive(32'hFFFF_FFFF, "R4");
    drive(32'h1234_5678, "R5");
    idle(3);

    // R8: fields hold while idle
    check({res_inv, res_pool, res_imm, res_rot} == last_fields, "R8", "fields held while idle",
          W'({res_inv, res_pool, res_imm, res_rot}), W'(last_fields));
    check(res_valid == 1'b0, "R6", "no pulse while idle", W'(res_valid), '0);

    // Random mix: fitting, complemented and arbitrary words
    for (int i = 0; i < 150; i++) begin
      logic [W-1:0] v;
      int sel;
      sel = int'($urandom % 3);
      v   = ror_w(IW'($urandom), 2 * int'($urandom % 16));
      if (sel == 1) v = ~v;
      if (sel == 2) v = $urandom;
      drive(v, sel == 0 ? "R1" : (sel == 1 ? "R4" : "R5"));
      if (($urandom % 5) == 0) idle(1 + int'($urandom % 3));
    end
    idle(4);
    check({res_inv, res_pool, res_imm, res_rot} == last_fields, "R8", "fields held after burst",
          W'({res_inv, res_pool, res_imm, res_rot}), W'(last_fields));
    check(exp_q.size() == 0, "R6", "every accepted input produced a result", W'(exp_q.size()), '0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule